// File: doc/BRIEF.md
# Front Panel Switch Scanner

This block runs an operator console made of four rows of eight switches and sixteen lamps. It selects one row at a time and reads that row's eight switch lines after a settle delay. It accepts a press only after several samples agree, and it acts on the press once. After acting, it waits until the switches are fully released before it looks for another press. Two rows are data switches. Each of these toggles one bit of a 16-bit data register, and the lamps always show that register. The other two rows are command switches. They move words between the data register and four machine registers: workspace pointer, program counter, status and memory address. They can also read or write the memory word at the memory address, or clear the data register.

Run, halt/single-step, reset and load are not carried out here. For those commands the block only raises an indication. Run and halt/single-step also end the panel session: the scanner stops until it is told to start a new session. Memory accesses go through a request/acknowledge port, and the scanner stalls on that port until the access is acknowledged.

Top module: `panel_scanner`

## Requirements
- R1: After reset the lamps show 0x0000, the workspace, program counter, status and memory address outputs are 0x0000, row_sel_o is 0, and run_lamp_o, sie_req_o, reset_pulse_o, load_pulse_o and mem_req_o are low.
- R2: Before a new press is looked for, the selected row must read all-zero on MATCH_CNT (default 3) consecutive samples. A switch that is held down therefore acts exactly once.
- R3: A row is accepted only when MATCH_CNT consecutive samples of it are non-zero. A press that covers fewer samples has no effect.
- R4: During the search, a zero sample moves row_sel_o to the next row, wrapping from 3 to 0, and samples are taken SETTLE_CYC cycles apart. Rows 0 and 1 carry command switches and rows 2 and 3 carry data switches. An even row supplies bits 15..8 of the 16-bit word and an odd row supplies bits 7..0, and sw_i[7] is the most significant bit of the row. row_sel_o does not change while a memory access is pending.
- R5: An accepted data row XORs its placed byte into the data register. For example, switches 3 and 5 of row 3 together flip bits 3 and 5.
- R6: On a command row, only the set bit nearest bit 15 of the placed word acts. Counting from bit 15 downward, the commands are: 0 halt/single-step, 1 run, 2 reset, 3 load, 4..7 show WP/PC/ST/MA, 8..11 set WP/PC/ST/MA, 12 memory read, 13 address step, 14 memory write, 15 clear.
- R7: A show command copies the named register into the data register. A set command copies the data register into the named register.
- R8: Clear zeroes the data register. Address step adds 2 to the memory address.
- R9: Memory read and memory write raise mem_req_o, with mem_addr_o equal to the memory address and mem_we_o equal to 1 for a write. The request and its address, write flag and write data stay constant until mem_ack_i. A read loads mem_rdata_i into the data register.
- R10: Reset and load each give a one-cycle pulse on their own output, at most one pulse output is high in any cycle, and scanning goes on afterwards.
- R11: Halt gives a one-cycle sie_req_o pulse and run sets run_lamp_o. Both end the session, so switches are ignored until session_start_i, which resumes scanning and turns the run lamp off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| session_start_i | input | 1 | Starts a new panel session after run or halt |
| sw_i | input | 8 | Switch lines of the selected row, 1 = pressed |
| row_sel_o | output | 2 | Selected switch row |
| lamp_o | output | 16 | Display lamps (data register) |
| wp_o | output | 16 | Workspace pointer register |
| pc_o | output | 16 | Program counter register |
| st_o | output | 16 | Status register |
| ma_o | output | 16 | Memory address register |
| run_lamp_o | output | 1 | Run lamp |
| sie_req_o | output | 1 | Single-instruction-execute request pulse |
| reset_pulse_o | output | 1 | Reset command pulse |
| load_pulse_o | output | 1 | Load command pulse |
| mem_req_o | output | 1 | Memory request |
| mem_we_o | output | 1 | Memory write flag |
| mem_addr_o | output | 16 | Memory address |
| mem_wdata_o | output | 16 | Memory write data |
| mem_ack_i | input | 1 | Memory acknowledge |
| mem_rdata_i | input | 16 | Memory read data |

## Verification
Two things can fall on the same acceptance sample. One is two command switches closing together on one row, so that the priority pick decides which command runs. The bench presses show-WP and show-ST at the same time and requires that the lamps show the workspace value. The other is a press that disappears before its last confirming sample. The bench applies a press shorter than two sample intervals and requires that the lamps stay unchanged. It also holds a switch for many scan periods and requires that its bit flips only once.

// File: rtl/panel_pkg.sv
package panel_pkg;
    localparam int unsigned PNL_COLS   = 8;
    localparam int unsigned PNL_ROWS   = 4;
    localparam int unsigned PNL_WORD_W = 2 * PNL_COLS;
    localparam int unsigned PNL_ROW_W  = $clog2(PNL_ROWS);
    localparam int unsigned PNL_HIT_W  = 4;

    typedef enum logic [1:0] {
        PS_RELEASE,
        PS_SCAN,
        PS_MEM,
        PS_IDLE
    } panel_state_e;

    // rank of the first set bit, counted from the word's MSB
    typedef enum logic [3:0] {
        CMD_HALT, CMD_RUN, CMD_RESET, CMD_LOAD,
        CMD_SHOW_WP, CMD_SHOW_PC, CMD_SHOW_ST, CMD_SHOW_MA,
        CMD_SET_WP, CMD_SET_PC, CMD_SET_ST, CMD_SET_MA,
        CMD_MEM_SHOW, CMD_MA_STEP, CMD_MEM_STORE, CMD_CLEAR
    } panel_cmd_e;

    typedef struct packed {
        panel_state_e            state;
        logic [PNL_ROW_W-1:0]    row;
        logic [PNL_HIT_W-1:0]    hits;
        logic [PNL_WORD_W-1:0]   data;
        logic [PNL_WORD_W-1:0]   wp;
        logic [PNL_WORD_W-1:0]   pc;
        logic [PNL_WORD_W-1:0]   st;
        logic [PNL_WORD_W-1:0]   ma;
        logic                    run_lamp;
        logic                    sie;
        logic                    rst_p;
        logic                    load_p;
        logic                    mem_we;
    } panel_regs_t;
endpackage

// File: rtl/pnl_settle.sv
module pnl_settle #(
    parameter int unsigned SETTLE_CYC = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    output logic tick
);
    localparam int unsigned CNT_W = $clog2(SETTLE_CYC + 1);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        tick  = en && (cnt_q == CNT_W'(SETTLE_CYC - 1));
        cnt_d = cnt_q;
        if (!en || tick) cnt_d = '0;
        else             cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/pnl_first_set.sv
module pnl_first_set #(
    parameter int unsigned W = 16
) (
    input  logic [W-1:0]         vec,
    output logic [$clog2(W)-1:0] rank,
    output logic                 found
);
    localparam int unsigned IDX_W = $clog2(W);

    always_comb begin
        found = 1'b0;
        rank  = '0;
        for (int i = 0; i < W; i++) begin
            if (vec[i]) begin
                found = 1'b1;
                rank  = IDX_W'(W - 1 - i);
            end
        end
    end
endmodule

// File: rtl/panel_scanner.sv
module panel_scanner
    import panel_pkg::*;
#(
    parameter int unsigned SETTLE_CYC = 4,
    parameter int unsigned MATCH_CNT  = 3
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   session_start_i,
    input  logic [PNL_COLS-1:0]    sw_i,
    output logic [PNL_ROW_W-1:0]   row_sel_o,
    output logic [PNL_WORD_W-1:0]  lamp_o,
    output logic [PNL_WORD_W-1:0]  wp_o,
    output logic [PNL_WORD_W-1:0]  pc_o,
    output logic [PNL_WORD_W-1:0]  st_o,
    output logic [PNL_WORD_W-1:0]  ma_o,
    output logic                   run_lamp_o,
    output logic                   sie_req_o,
    output logic                   reset_pulse_o,
    output logic                   load_pulse_o,
    output logic                   mem_req_o,
    output logic                   mem_we_o,
    output logic [PNL_WORD_W-1:0]  mem_addr_o,
    output logic [PNL_WORD_W-1:0]  mem_wdata_o,
    input  logic                   mem_ack_i,
    input  logic [PNL_WORD_W-1:0]  mem_rdata_i
);
    localparam logic [PNL_HIT_W-1:0] LAST_HIT = PNL_HIT_W'(MATCH_CNT - 1);
    localparam int unsigned          RANK_W   = $clog2(PNL_WORD_W);

    panel_regs_t r_d, r_q;

    logic                   tick;
    logic                   row_busy;
    logic [PNL_WORD_W-1:0]  placed;
    logic [RANK_W-1:0]      rank;
    logic                   found;

    assign placed = r_q.row[0] ? {{PNL_COLS{1'b0}}, sw_i} : {sw_i, {PNL_COLS{1'b0}}};
    assign row_busy = |sw_i;

    pnl_settle #(.SETTLE_CYC(SETTLE_CYC)) i_settle (
        .clk   (clk),
        .rst_n (rst_n),
        .en    ((r_q.state == PS_RELEASE) || (r_q.state == PS_SCAN)),
        .tick  (tick)
    );

    pnl_first_set #(.W(PNL_WORD_W)) i_first (
        .vec   (placed),
        .rank  (rank),
        .found (found)
    );

    always_comb begin
        r_d        = r_q;
        r_d.sie    = 1'b0;
        r_d.rst_p  = 1'b0;
        r_d.load_p = 1'b0;

        unique case (r_q.state)
            PS_RELEASE: begin
                if (tick) begin
                    if (row_busy) begin
                        r_d.hits = '0;
                    end else if (r_q.hits == LAST_HIT) begin
                        r_d.hits  = '0;
                        r_d.state = PS_SCAN;
                    end else begin
                        r_d.hits = r_q.hits + 1'b1;
                    end
                end
            end
            PS_SCAN: begin
                if (tick) begin
                    if (!row_busy) begin
                        r_d.hits = '0;
                        r_d.row  = r_q.row + 1'b1;
                    end else if (r_q.hits != LAST_HIT) begin
                        r_d.hits = r_q.hits + 1'b1;
                    end else begin
                        r_d.hits  = '0;
                        r_d.state = PS_RELEASE;
                        if (r_q.row[PNL_ROW_W-1]) begin
                            r_d.data = r_q.data ^ placed;
                        end else if (found) begin
                            unique case (panel_cmd_e'(rank))
                                CMD_HALT:      begin r_d.sie = 1'b1; r_d.state = PS_IDLE; end
                                CMD_RUN:       begin r_d.run_lamp = 1'b1; r_d.state = PS_IDLE; end
                                CMD_RESET:     r_d.rst_p  = 1'b1;
                                CMD_LOAD:      r_d.load_p = 1'b1;
                                CMD_SHOW_WP:   r_d.data = r_q.wp;
                                CMD_SHOW_PC:   r_d.data = r_q.pc;
                                CMD_SHOW_ST:   r_d.data = r_q.st;
                                CMD_SHOW_MA:   r_d.data = r_q.ma;
                                CMD_SET_WP:    r_d.wp = r_q.data;
                                CMD_SET_PC:    r_d.pc = r_q.data;
                                CMD_SET_ST:    r_d.st = r_q.data;
                                CMD_SET_MA:    r_d.ma = r_q.data;
                                CMD_MEM_SHOW:  begin r_d.mem_we = 1'b0; r_d.state = PS_MEM; end
                                CMD_MA_STEP:   r_d.ma = r_q.ma + PNL_WORD_W'(2);
                                CMD_MEM_STORE: begin r_d.mem_we = 1'b1; r_d.state = PS_MEM; end
                                CMD_CLEAR:     r_d.data = '0;
                                default:       r_d.data = r_q.data;
                            endcase
                        end
                    end
                end
            end
            PS_MEM: begin
                if (mem_ack_i) begin
                    if (!r_q.mem_we) r_d.data = mem_rdata_i;
                    r_d.state = PS_RELEASE;
                end
            end
            PS_IDLE: begin
                if (session_start_i) begin
                    r_d.state    = PS_RELEASE;
                    r_d.hits     = '0;
                    r_d.run_lamp = 1'b0;
                end
            end
            default: r_d.state = PS_RELEASE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign row_sel_o     = r_q.row;
    assign lamp_o        = r_q.data;
    assign wp_o          = r_q.wp;
    assign pc_o          = r_q.pc;
    assign st_o          = r_q.st;
    assign ma_o          = r_q.ma;
    assign run_lamp_o    = r_q.run_lamp;
    assign sie_req_o     = r_q.sie;
    assign reset_pulse_o = r_q.rst_p;
    assign load_pulse_o  = r_q.load_p;
    assign mem_req_o     = (r_q.state == PS_MEM);
    assign mem_we_o      = r_q.mem_we;
    assign mem_addr_o    = r_q.ma;
    assign mem_wdata_o   = r_q.data;
endmodule

// File: rtl/panel_scanner_chk.sv
module panel_scanner_chk (
    input logic        clk,
    input logic        rst_n,
    input logic [1:0]  row_sel_o,
    input logic        run_lamp_o,
    input logic        sie_req_o,
    input logic        reset_pulse_o,
    input logic        load_pulse_o,
    input logic        mem_req_o,
    input logic        mem_we_o,
    input logic [15:0] mem_addr_o,
    input logic [15:0] mem_wdata_o,
    input logic        mem_ack_i
);
    AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_o && !mem_ack_i |=> mem_req_o); // R9
    AST_REQ_FIELDS_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_o && !mem_ack_i |=> $stable(mem_addr_o) && $stable(mem_we_o) && $stable(mem_wdata_o)); // R9
    AST_ROW_FROZEN_IN_MEM: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_o |=> $stable(row_sel_o)); // R4
    AST_PULSES_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({sie_req_o, reset_pulse_o, load_pulse_o})); // R10
    AST_RESET_PULSE_SHORT: assert property (@(posedge clk) disable iff (!rst_n)
        reset_pulse_o |=> !reset_pulse_o); // R10
    AST_LOAD_PULSE_SHORT: assert property (@(posedge clk) disable iff (!rst_n)
        load_pulse_o |=> !load_pulse_o); // R10
    AST_HALT_STOPS_MEM: assert property (@(posedge clk) disable iff (!rst_n)
        sie_req_o |=> !mem_req_o && !sie_req_o); // R11
    AST_RUN_NO_MEM: assert property (@(posedge clk) disable iff (!rst_n)
        run_lamp_o |-> !mem_req_o); // R11
endmodule

bind panel_scanner panel_scanner_chk i_panel_scanner_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .row_sel_o     (row_sel_o),
    .run_lamp_o    (run_lamp_o),
    .sie_req_o     (sie_req_o),
    .reset_pulse_o (reset_pulse_o),
    .load_pulse_o  (load_pulse_o),
    .mem_req_o     (mem_req_o),
    .mem_we_o      (mem_we_o),
    .mem_addr_o    (mem_addr_o),
    .mem_wdata_o   (mem_wdata_o),
    .mem_ack_i     (mem_ack_i)
);

// File: tb/test_panel_scanner.sv
module test_panel_scanner;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        session_start = 1'b0;
    logic [31:0] pressed = '0;
    logic [7:0]  sw;
    logic [1:0]  row_sel;
    logic [15:0] lamp, wp, pc, st, ma, maddr, mwdata, mrdata;
    logic        run_lamp, sie, rst_p, load_p, mreq, mwe;
    logic        mack = 1'b0;
    logic [15:0] mem [16];
    logic [1:0]  wait_cnt = '0;

    int n_cmp = 0, n_bad = 0;
    int n_sie = 0, n_rst = 0, n_load = 0, n_wr = 0;
    logic [15:0] exp_lamp = '0;

    always #2 clk = ~clk;

    assign sw     = pressed[row_sel*8 +: 8];
    assign mrdata = mem[maddr[4:1]];

    panel_scanner i_panel_scanner (
        .clk(clk), .rst_n(rst_n), .session_start_i(session_start), .sw_i(sw),
        .row_sel_o(row_sel), .lamp_o(lamp), .wp_o(wp), .pc_o(pc), .st_o(st), .ma_o(ma),
        .run_lamp_o(run_lamp), .sie_req_o(sie), .reset_pulse_o(rst_p), .load_pulse_o(load_p),
        .mem_req_o(mreq), .mem_we_o(mwe), .mem_addr_o(maddr), .mem_wdata_o(mwdata),
        .mem_ack_i(mack), .mem_rdata_i(mrdata)
    );

    // memory model: acknowledge on the third cycle of a request
    always @(posedge clk) begin
        mack <= 1'b0;
        if (mreq && !mack) begin
            if (wait_cnt == 2'd2) begin
                mack     <= 1'b1;
                wait_cnt <= '0;
                if (mwe) begin
                    mem[maddr[4:1]] <= mwdata;
                    n_wr <= n_wr + 1;
                end
            end else begin
                wait_cnt <= wait_cnt + 1'b1;
            end
        end
    end

    always @(posedge clk) begin
        if (rst_n) begin
            if (sie)    n_sie  <= n_sie + 1;
            if (rst_p)  n_rst  <= n_rst + 1;
            if (load_p) n_load <= n_load + 1;
        end
    end

    function automatic logic [31:0] cmd_mask(input int k);
        return 32'd1 << ((k / 8) * 8 + 7 - (k % 8));
    endfunction

    function automatic logic [31:0] data_mask(input int b);
        return 32'd1 << (((b >= 8) ? 16 : 24) + (b % 8));
    endfunction

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tap(input logic [31:0] m);
        pressed = m;
        repeat (80) @(negedge clk);
        pressed = '0;
        repeat (40) @(negedge clk);
    endtask

    task automatic finish_run;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    task automatic t_reset;
        check("R1 lamp", lamp, 16'h0);
        check("R1 wp", wp, 16'h0);
        check("R1 ma", ma, 16'h0);
        check("R1 row", {14'd0, row_sel}, 16'h0);
        check("R1 flags", {11'd0, run_lamp, sie, rst_p, load_p, mreq}, 16'h0);
    endtask

    task automatic t_data;
        tap(data_mask(15)); exp_lamp ^= 16'h8000;
        check("R4 R5 upper byte bit15", lamp, exp_lamp);
        tap(data_mask(0));  exp_lamp ^= 16'h0001;
        check("R4 R5 lower byte bit0", lamp, exp_lamp);
        tap(data_mask(3) | data_mask(5)); exp_lamp ^= 16'h0028;
        check("R5 two bits one row", lamp, exp_lamp);
    endtask

    task automatic t_hold_and_glitch;
        pressed = data_mask(1);
        repeat (400) @(negedge clk);
        pressed = '0;
        repeat (40) @(negedge clk);
        exp_lamp ^= 16'h0002;
        check("R2 held press acts once", lamp, exp_lamp);
        pressed = data_mask(2);
        repeat (6) @(negedge clk);
        pressed = '0;
        repeat (60) @(negedge clk);
        check("R3 short press ignored", lamp, exp_lamp);
    endtask

    task automatic t_regs;
        tap(cmd_mask(8));
        check("R7 set WP", wp, exp_lamp);
        tap(cmd_mask(9));
        check("R7 set PC", pc, exp_lamp);
        tap(cmd_mask(15)); exp_lamp = 16'h0;
        check("R8 clear", lamp, exp_lamp);
        tap(cmd_mask(4)); exp_lamp = wp;
        check("R7 show WP", lamp, 16'h802B);
        tap(cmd_mask(15));
        tap(data_mask(3)); exp_lamp = 16'h0008;
        tap(cmd_mask(11));
        check("R7 set MA", ma, 16'h0008);
    endtask

    task automatic t_memory;
        tap(data_mask(15)); exp_lamp = 16'h8008;
        tap(cmd_mask(14));
        check("R9 write data", mem[4], 16'h8008);
        check("R9 write count", 16'(n_wr), 16'd1);
        tap(cmd_mask(13));
        check("R8 address step", ma, 16'h000A);
        tap(cmd_mask(15));
        tap(cmd_mask(12)); exp_lamp = 16'h1234;
        check("R9 read data", lamp, exp_lamp);
        tap(cmd_mask(7));
        check("R7 show MA", lamp, 16'h000A);
    endtask

    task automatic t_priority;
        tap(cmd_mask(10));
        check("R7 set ST", st, 16'h000A);
        tap(cmd_mask(4) | cmd_mask(6));
        check("R6 first from MSB wins", lamp, 16'h802B);
        tap(cmd_mask(13) | cmd_mask(15));
        check("R6 second row priority", ma, 16'h000C);
        check("R6 lower command skipped", lamp, 16'h802B);
    endtask

    task automatic t_pulses;
        tap(cmd_mask(2));
        check("R10 reset pulse count", 16'(n_rst), 16'd1);
        tap(cmd_mask(3));
        check("R10 load pulse count", 16'(n_load), 16'd1);
        tap(data_mask(0));
        check("R10 scanning continues", lamp, 16'h802A);
    endtask

    task automatic t_session;
        tap(cmd_mask(0));
        check("R11 halt pulse", 16'(n_sie), 16'd1);
        tap(data_mask(4));
        check("R11 switches ignored after halt", lamp, 16'h802A);
        @(negedge clk) session_start = 1'b1;
        @(negedge clk) session_start = 1'b0;
        repeat (20) @(negedge clk);
        tap(cmd_mask(1));
        check("R11 run lamp on", {15'd0, run_lamp}, 16'd1);
        tap(data_mask(4));
        check("R11 switches ignored after run", lamp, 16'h802A);
        @(negedge clk) session_start = 1'b1;
        @(negedge clk) session_start = 1'b0;
        repeat (20) @(negedge clk);
        check("R11 start clears run lamp", {15'd0, run_lamp}, 16'd0);
        tap(data_mask(4));
        check("R11 scanning resumes", lamp, 16'h803A);
    endtask

    initial begin
        for (int i = 0; i < 16; i++) mem[i] = 16'h0;
        mem[5] = 16'h1234;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_data();
        t_hold_and_glitch();
        t_regs();
        t_memory();
        t_priority();
        t_pulses();
        t_session();
        finish_run();
    end

    initial begin
        #(4 * 150000);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_run();
    end
endmodule